// File: doc/BRIEF.md
# Fault-Masked Complementary PWM Output Stage with Deadtime

This block is the last stage before the pins of one PWM channel. It takes a single PWM reference and drives a complementary pair of outputs, A and B, plus an auxiliary output X. In complementary mode the pair follows the reference, A in phase and B inverted. Every switching edge opens a programmable gap in which both A and B are low. The gap before A turns on and the gap before B turns on are set separately. In independent mode A follows the reference and B follows a separate drive input, both with no delay.

Four shared fault inputs can shut off the outputs. Each of the three outputs has its own 4-bit mask that chooses which faults are allowed to force it low. This gating sits after deadtime insertion and is purely combinational, so a mapped fault removes drive in the same cycle it appears. A small write port with an address and write enable loads the two deadtime counts and the three masks. The counter that produces the reference and any filtering of the fault inputs live outside this block.

Top module: `pwm_fault_dt_stage`

## Requirements
- R1: After reset all three fault masks are all ones, so any single fault input forces A, B and X low.
- R2: After reset both deadtime counts hold 0x7FF, which gives a gap of 4095 clock cycles.
- R3: Fault gating is combinational. The output drops in the same cycle the mapped fault rises and returns in the same cycle it clears.
- R4: A fault whose bit is 0 in an output's mask has no effect on that output. Mask bit i corresponds to fault input bit i.
- R5: In complementary mode, a rising reference edge seen at clock edge k drives B low at k. A goes high at edge k+2*Crise+1, where Crise is the count at address 0.
- R6: In complementary mode, a falling reference edge seen at edge k drives A low at k. B goes high at edge k+2*Cfall+1, where Cfall is the count at address 1.
- R7: In complementary mode, A and B are never high at the same time.
- R8: If the reference toggles again while a gap is still running, the pending turn-on is dropped. A new gap starts for the new edge.
- R9: In independent mode (cmp_en=0), out_a follows pwm_ref and out_b follows pwm_b_ind combinationally, subject only to fault gating.
- R10: out_x follows x_drive combinationally in both modes, subject only to fault gating.
- R11: A write with cfg_we=1 takes effect at the next clock edge. Address 0 takes the rise count from cfg_wdata[10:0] and address 1 takes the fall count. Addresses 2, 3 and 4 take the masks of A, B and X from cfg_wdata[3:0]. Addresses 5 to 7 change nothing.
- R12: During reset A and B are low. In complementary mode with the reference low, B goes high at the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_en | input | 1 | 1 = complementary mode with deadtime, 0 = independent mode |
| pwm_ref | input | 1 | PWM reference, drives A (and B inverted in complementary mode) |
| pwm_b_ind | input | 1 | B drive used in independent mode |
| x_drive | input | 1 | Drive for the auxiliary output X |
| fault_in | input | 4 | Fault inputs, active high |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 11 | Configuration write data |
| out_a | output | 1 | Gated output A |
| out_b | output | 1 | Gated output B |
| out_x | output | 1 | Gated output X |

## Verification
The case that is hardest to reach from the ports is a reference that toggles back while a gap is still counting. That case has to show that the earlier turn-on never happens and that the new gap is measured from the second edge. The stimulus raises the reference with an 11-cycle rise gap loaded. It pulls the reference low three cycles later and confirms that A stays low. It then counts the cycles until B returns, and checks at every sampled cycle that A and B are never high together. The default 4095-cycle gap after reset is measured by counting clocks until A rises. Mask-to-fault routing is covered by a table of mask and fault patterns applied in independent mode.

// File: rtl/pwm_fdm_pkg.sv
package pwm_fdm_pkg;

    localparam int NUM_FAULT = 4;
    localparam int NUM_OUT   = 3;
    localparam int CNT_W     = 11;
    localparam int DT_W      = CNT_W + 1;
    localparam int ADDR_W    = 3;

    localparam int CH_A = 0;
    localparam int CH_B = 1;
    localparam int CH_X = 2;

    localparam logic [CNT_W-1:0] CNT_RST = 11'h7FF;

    typedef enum logic [ADDR_W-1:0] {
        CFG_DT_RISE = 3'd0,
        CFG_DT_FALL = 3'd1,
        CFG_MASK_A  = 3'd2,
        CFG_MASK_B  = 3'd3,
        CFG_MASK_X  = 3'd4
    } cfg_addr_e;

    localparam int MASK_BASE = int'(CFG_MASK_A);

    typedef logic [NUM_FAULT-1:0] fault_vec_t;

    typedef struct packed {
        logic a;
        logic b;
    } pair_t;

    // Gap length in clocks for a programmed count: 2*count + 1.
    function automatic logic [DT_W-1:0] dt_cycles(input logic [CNT_W-1:0] cnt);
        return {cnt, 1'b1};
    endfunction

endpackage

// File: rtl/pwm_fdm_regs.sv
module pwm_fdm_regs
    import pwm_fdm_pkg::*;
#(
    parameter int P_CNT_W     = CNT_W,
    parameter int P_NUM_FAULT = NUM_FAULT,
    parameter int P_NUM_OUT   = NUM_OUT,
    parameter int P_ADDR_W    = ADDR_W,
    parameter logic [P_CNT_W-1:0] P_CNT_RST = CNT_RST
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  we,
    input  logic [P_ADDR_W-1:0]                   addr,
    input  logic [P_CNT_W-1:0]                    wdata,
    output logic [P_CNT_W-1:0]                    rise_cnt,
    output logic [P_CNT_W-1:0]                    fall_cnt,
    output logic [P_NUM_OUT-1:0][P_NUM_FAULT-1:0] mask
);

    localparam int LAST_ADDR = MASK_BASE + P_NUM_OUT - 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            rise_cnt <= P_CNT_RST;
            fall_cnt <= P_CNT_RST;
        end else if (we) begin
            if (addr == P_ADDR_W'(CFG_DT_RISE)) rise_cnt <= wdata;
            if (addr == P_ADDR_W'(CFG_DT_FALL)) fall_cnt <= wdata;
        end
    end

    for (genvar g = 0; g < P_NUM_OUT; g++) begin : g_mask
        always_ff @(posedge clk) begin
            if (rst)
                mask[g] <= '1;
            else if (we && addr == P_ADDR_W'(MASK_BASE + g))
                mask[g] <= wdata[P_NUM_FAULT-1:0];
        end

        // R1
        r1_mask_reset_chk: assert property (@(posedge clk)
            rst |=> (mask[g] == '1));

        // R11
        r11_mask_write_chk: assert property (@(posedge clk) disable iff (rst)
            (we && addr == P_ADDR_W'(MASK_BASE + g)) |=> (mask[g] == $past(wdata[P_NUM_FAULT-1:0])));
    end

    // R2
    r2_count_reset_chk: assert property (@(posedge clk)
        rst |=> (rise_cnt == P_CNT_RST && fall_cnt == P_CNT_RST));

    // R11
    r11_ignored_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (we && int'(addr) > LAST_ADDR) |=> ($stable(mask) && $stable(rise_cnt) && $stable(fall_cnt)));

endmodule

// File: rtl/pwm_fdm_deadtime.sv
module pwm_fdm_deadtime
    import pwm_fdm_pkg::*;
#(
    parameter int P_CNT_W = CNT_W,
    parameter int P_DT_W  = P_CNT_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ref_i,
    input  logic [P_CNT_W-1:0] rise_cnt,
    input  logic [P_CNT_W-1:0] fall_cnt,
    output pair_t              pair_o
);

    logic              ref_q;
    logic [P_DT_W-1:0] timer;
    logic              edge_seen;
    logic [P_DT_W-1:0] gap_len;

    assign edge_seen = (ref_i != ref_q);
    assign gap_len   = ref_i ? P_DT_W'(dt_cycles(rise_cnt)) : P_DT_W'(dt_cycles(fall_cnt));

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q  <= 1'b0;
            pair_o <= '{a: 1'b0, b: 1'b0};
            timer  <= P_DT_W'(1);
        end else begin
            ref_q <= ref_i;
            if (edge_seen) begin
                pair_o <= '{a: 1'b0, b: 1'b0};
                timer  <= gap_len;
            end else if (timer == P_DT_W'(1)) begin
                pair_o <= '{a: ref_q, b: ~ref_q};
                timer  <= '0;
            end else if (timer != '0) begin
                timer <= timer - 1'b1;
            end
        end
    end

    // R7
    r7_no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(pair_o.a && pair_o.b));

    // R5
    r5_edge_low_chk: assert property (@(posedge clk) disable iff (rst)
        edge_seen |=> (!pair_o.a && !pair_o.b));

    // R8
    r8_gap_low_chk: assert property (@(posedge clk) disable iff (rst)
        (timer != '0) |-> (!pair_o.a && !pair_o.b));

endmodule

// File: rtl/pwm_fdm_gate.sv
module pwm_fdm_gate
    import pwm_fdm_pkg::*;
#(
    parameter int P_NUM_FAULT = NUM_FAULT
) (
    input  logic                   drive_i,
    input  logic [P_NUM_FAULT-1:0] fault_i,
    input  logic [P_NUM_FAULT-1:0] mask_i,
    output logic                   out_o
);

    logic kill;

    assign kill  = |(fault_i & mask_i);
    assign out_o = drive_i & ~kill;

endmodule

// File: rtl/pwm_fault_dt_stage.sv
module pwm_fault_dt_stage
    import pwm_fdm_pkg::*;
#(
    parameter int P_NUM_FAULT = NUM_FAULT,
    parameter int P_CNT_W     = CNT_W,
    parameter int P_ADDR_W    = ADDR_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmp_en,
    input  logic                   pwm_ref,
    input  logic                   pwm_b_ind,
    input  logic                   x_drive,
    input  logic [P_NUM_FAULT-1:0] fault_in,
    input  logic                   cfg_we,
    input  logic [P_ADDR_W-1:0]    cfg_addr,
    input  logic [P_CNT_W-1:0]     cfg_wdata,
    output logic                   out_a,
    output logic                   out_b,
    output logic                   out_x
);

    localparam int N_OUT = NUM_OUT;

    logic [P_CNT_W-1:0]                rise_cnt;
    logic [P_CNT_W-1:0]                fall_cnt;
    logic [N_OUT-1:0][P_NUM_FAULT-1:0] mask;
    pair_t                             dt_pair;
    logic [N_OUT-1:0]                  pre_drive;
    logic [N_OUT-1:0]                  gated;

    pwm_fdm_regs #(
        .P_CNT_W     (P_CNT_W),
        .P_NUM_FAULT (P_NUM_FAULT),
        .P_NUM_OUT   (N_OUT),
        .P_ADDR_W    (P_ADDR_W),
        .P_CNT_RST   (P_CNT_W'(CNT_RST))
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .rise_cnt (rise_cnt),
        .fall_cnt (fall_cnt),
        .mask     (mask)
    );

    pwm_fdm_deadtime #(
        .P_CNT_W (P_CNT_W)
    ) u_dt (
        .clk      (clk),
        .rst      (rst),
        .ref_i    (pwm_ref),
        .rise_cnt (rise_cnt),
        .fall_cnt (fall_cnt),
        .pair_o   (dt_pair)
    );

    always_comb begin
        pre_drive[CH_A] = cmp_en ? dt_pair.a : pwm_ref;
        pre_drive[CH_B] = cmp_en ? dt_pair.b : pwm_b_ind;
        pre_drive[CH_X] = x_drive;
    end

    for (genvar g = 0; g < N_OUT; g++) begin : g_gate
        pwm_fdm_gate #(
            .P_NUM_FAULT (P_NUM_FAULT)
        ) u_gate (
            .drive_i (pre_drive[g]),
            .fault_i (fault_in),
            .mask_i  (mask[g]),
            .out_o   (gated[g])
        );

        // R3
        r3_fault_kill_chk: assert property (@(posedge clk) disable iff (rst)
            (|(fault_in & mask[g])) |-> !gated[g]);
    end

    assign out_a = gated[CH_A];
    assign out_b = gated[CH_B];
    assign out_x = gated[CH_X];

    // R7
    r7_pin_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        cmp_en |-> !(out_a && out_b));

    // R4
    r4_unmasked_pass_chk: assert property (@(posedge clk) disable iff (rst)
        ((fault_in & mask[CH_X]) == '0) |-> (out_x == x_drive));

endmodule

// File: tb/pwm_fault_dt_stage_tb.sv
module pwm_fault_dt_stage_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmp_en;
    logic        pwm_ref;
    logic        pwm_b_ind;
    logic        x_drive;
    logic [3:0]  fault_in;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic [10:0] cfg_wdata;
    logic        out_a;
    logic        out_b;
    logic        out_x;

    int n_tests = 0;
    int n_fail  = 0;
    int overlap = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_fault_dt_stage u_dut (
        .clk(clk), .rst(rst), .cmp_en(cmp_en), .pwm_ref(pwm_ref),
        .pwm_b_ind(pwm_b_ind), .x_drive(x_drive), .fault_in(fault_in),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .out_a(out_a), .out_b(out_b), .out_x(out_x)
    );

    // {fault, maskA, maskB, maskX, ref, b_ind, x, expected {a,b,x}}
    localparam logic [21:0] VEC [NVEC] = '{
        {4'b0000, 4'b1111, 4'b1111, 4'b1111, 1'b1, 1'b1, 1'b1, 3'b111},
        {4'b0001, 4'b0001, 4'b0000, 4'b0000, 1'b1, 1'b1, 1'b1, 3'b011},
        {4'b0100, 4'b1011, 4'b0100, 4'b0000, 1'b1, 1'b1, 1'b1, 3'b101},
        {4'b1000, 4'b0000, 4'b0000, 4'b1000, 1'b1, 1'b1, 1'b1, 3'b110},
        {4'b1111, 4'b0000, 4'b0000, 4'b0000, 1'b1, 1'b1, 1'b1, 3'b111},
        {4'b0110, 4'b0010, 4'b0001, 4'b0100, 1'b1, 1'b1, 1'b1, 3'b010},
        {4'b0000, 4'b1111, 4'b1111, 4'b1111, 1'b0, 1'b1, 1'b0, 3'b010},
        {4'b0010, 4'b1101, 4'b1101, 4'b1101, 1'b1, 1'b0, 1'b1, 3'b101}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [10:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drive a reference edge and return the clocks until the newly-on output rises.
    task automatic edge_delay(input logic new_ref, output int gap);
        int n;
        @(negedge clk);
        pwm_ref = new_ref;
        n = 0;
        do begin
            @(posedge clk); #1;
            n++;
            if (out_a && out_b) overlap++;
        end while (!(new_ref ? out_a : out_b) && n < 6000);
        gap = n - 1;
    endtask

    initial begin
        int gap;
        rst = 1'b1; cmp_en = 1'b1; pwm_ref = 1'b0; pwm_b_ind = 1'b0;
        x_drive = 1'b0; fault_in = 4'b0; cfg_we = 1'b0; cfg_addr = 3'd0; cfg_wdata = '0;

        repeat (3) @(posedge clk);
        #1;
        chk("R12 reset a", int'(out_a), 0);
        chk("R12 reset b", int'(out_b), 0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        chk("R12 b on after reset", int'(out_b), 1);
        chk("R12 a off after reset", int'(out_a), 0);

        // R1 / R3: default masks, same-cycle kill and restore
        @(negedge clk); x_drive = 1'b1; fault_in = 4'b0100; #1;
        chk("R1 b killed by any fault", int'(out_b), 0);
        chk("R1 x killed by any fault", int'(out_x), 0);
        fault_in = 4'b0000; #1;
        chk("R3 b restored same cycle", int'(out_b), 1);
        chk("R3 x restored same cycle", int'(out_x), 1);
        fault_in = 4'b0001; #1;
        chk("R3 x dropped same cycle", int'(out_x), 0);
        fault_in = 4'b0000;

        // R2: default gap 4095
        edge_delay(1'b1, gap);
        chk("R2 default rise gap", gap, 4095);

        // R11 / R5 / R6: program counts
        wr(3'd0, 11'd5);
        wr(3'd1, 11'd2);
        edge_delay(1'b0, gap);
        chk("R6 fall gap 2*2+1", gap, 5);
        chk("R6 a low after fall", int'(out_a), 0);
        edge_delay(1'b1, gap);
        chk("R5 rise gap 2*5+1", gap, 11);
        chk("R5 b low after rise", int'(out_b), 0);
        wr(3'd0, 11'd0);
        edge_delay(1'b0, gap);
        chk("R6 fall gap again", gap, 5);
        edge_delay(1'b1, gap);
        chk("R5 rise gap count zero", gap, 1);

        // R8: retoggle during gap
        wr(3'd0, 11'd5);
        edge_delay(1'b0, gap);
        @(negedge clk); pwm_ref = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R8 a still low mid gap", int'(out_a), 0);
        edge_delay(1'b0, gap);
        chk("R8 restarted fall gap", gap, 5);
        chk("R8 a never turned on", int'(out_a), 0);
        repeat (15) begin
            @(posedge clk); #1;
            if (out_a && out_b) overlap++;
        end
        chk("R8 a stays low after cancel", int'(out_a), 0);
        chk("R7 no overlap seen", overlap, 0);

        // R10: X in complementary mode
        @(negedge clk); x_drive = 1'b0; #1;
        chk("R10 x follows drive low", int'(out_x), 0);
        x_drive = 1'b1; #1;
        chk("R10 x follows drive high", int'(out_x), 1);

        // R4 / R11: mask X to fault 0 only, timing and ignored addresses
        wr(3'd4, 11'b0001);
        @(negedge clk); fault_in = 4'b0010; #1;
        chk("R4 unmasked fault ignored", int'(out_x), 1);
        fault_in = 4'b0001; #1;
        chk("R4 masked fault kills", int'(out_x), 0);
        wr(3'd7, 11'd0);
        #1;
        chk("R11 addr 7 ignored", int'(out_x), 0);
        wr(3'd5, 11'd0);
        #1;
        chk("R11 addr 5 ignored", int'(out_x), 0);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = 3'd4; cfg_wdata = 11'd0; #1;
        chk("R11 old mask before edge", int'(out_x), 0);
        @(posedge clk); #1;
        chk("R11 new mask after edge", int'(out_x), 1);
        @(negedge clk); cfg_we = 1'b0; fault_in = 4'b0000;

        // R9 / R4: vector table in independent mode
        @(negedge clk); cmp_en = 1'b0;
        for (int i = 0; i < NVEC; i++) begin
            wr(3'd2, {7'd0, VEC[i][17:14]});
            wr(3'd3, {7'd0, VEC[i][13:10]});
            wr(3'd4, {7'd0, VEC[i][9:6]});
            @(negedge clk);
            fault_in = VEC[i][21:18]; pwm_ref = VEC[i][5];
            pwm_b_ind = VEC[i][4]; x_drive = VEC[i][3];
            #1;
            chk($sformatf("R9 vector %0d outputs", i), int'({out_a, out_b, out_x}), int'(VEC[i][2:0]));
        end
        @(negedge clk); fault_in = 4'b0000; pwm_ref = 1'b0; #1;
        chk("R9 a follows ref with no delay", int'(out_a), 0);
        pwm_b_ind = 1'b1; #1;
        chk("R9 b follows b_ind", int'(out_b), 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule